// File: doc/BRIEF.md
# Synchronous UART Master with Gated Serial Clock

This block is a serial master that sends and receives bytes in an asynchronous-style frame and also drives a serial clock line. A slave built like an SPI shift register can follow the data with that clock. A byte is offered on a valid/ready pair. Once it is accepted, the line carries a low start bit, then eight data bits with the least significant bit first, then a high stop bit. The clock line moves only while the eight data bits are on the line. It rests at the polarity level during the start bit, the stop bit and idle time.

Each bit lasts two half-periods. A half-period is a programmable number of system clocks. In every data bit the clock line makes one full cycle, and the phase setting selects which half of the bit holds the inverted level. The slave's reply on the input line is captured at the mid-bit clock transition. It is assembled into a byte and announced with a one-cycle done pulse at the start of the stop bit. Polarity, phase and the half-period length are taken at the moment a byte is accepted, so the settings of a frame cannot change while that frame is running.

Top module: `usync_master`

## Requirements
- R1: While idle, `tx_ready` is 1, `txd` is 1 and `sclk` equals the live `cfg_cpol` input.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, `tx_ready` stays 0 until the stop bit ends. `tx_valid` and `tx_data` are ignored while busy.
- R3: After acceptance, `txd` sends a start bit of 0, then `tx_data` bits 0 through 7 in that order, then a stop bit of 1. Every bit lasts 2*H system clocks.
- R4: `sclk` holds the latched polarity level for the whole start bit and the whole stop bit.
- R5: During a data bit with phase 0, `sclk` equals the polarity for the first H clocks and the inverse for the last H clocks. With phase 1 the two halves are swapped.
- R6: `rxd` is sampled in the last system clock of the first half of each data bit. Bit k of the received byte is the value sampled during data bit k.
- R7: `rx_done` is a single-cycle pulse in the first cycle of the stop bit, and `rx_data` carries the received byte in that cycle. `rx_data` changes only when `rx_done` is 1.
- R8: `cfg_cpol`, `cfg_cpha` and `baud_div` are latched at acceptance. Changing them during a frame has no effect on that frame.
- R9: H equals `baud_div`, except that a `baud_div` of 0 is treated as 1.
- R10: While `rst` is high and after it, until the first acceptance: `tx_ready`=1, `txd`=1, `rx_done`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Clock polarity: rest level of `sclk` |
| cfg_cpha | input | 1 | Clock phase: 1 puts the inverted level in the first half of each data bit |
| baud_div | input | 16 | Half-bit length in system clocks (0 acts as 1) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block idle, can accept a byte |
| txd | output | 1 | Serial data out |
| sclk | output | 1 | Gated serial clock out |
| rxd | input | 1 | Serial data in from the slave |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
The bound assertions check the idle levels of `txd` and `sclk` on every cycle, and that `tx_ready` drops after each acceptance. They also check that a start bit follows acceptance, that the done pulse lasts one cycle, and that `rx_data` holds between pulses. Only the bench's scenarios can show the full bit order, the exact bit and half-bit lengths for each divider value, and the clock waveform for all four polarity and phase settings. The same holds for the mid-bit receive sampling point and for the frame's immunity to settings changed while it runs. To expose these, the bench drives the opposite level on `rxd` during the second half of each data bit and changes the settings in the middle of a frame.

// File: rtl/usync_pkg.sv
package usync_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic pol;
        logic pha;
    } clkcfg_t;

    // level of the serial clock inside a data bit
    function automatic logic data_clk_level(clkcfg_t c, logic second_half);
        return c.pol ^ (c.pha ^ second_half);
    endfunction

    // zero divider is clamped to one
    function automatic logic [15:0] clamp_div(logic [15:0] d);
        return (d == '0) ? 16'd1 : d;
    endfunction

endpackage

// File: rtl/usync_timer.sv
module usync_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             half_end,
    output logic             second_half
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             half_q;

    assign half_end    = run && (cnt_q == div_q - 1'b1);
    assign second_half = half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= {{(DIV_W-1){1'b0}}, 1'b1};
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (load) begin
            div_q  <= (div_in == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_in;
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (run) begin
            if (half_end) begin
                cnt_q  <= '0;
                half_q <= ~half_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usync_seq.sv
module usync_seq
    import usync_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             half_end,
    input  logic             second_half,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             shift_now,
    output logic             sample_now,
    output logic             finish_now
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             bit_end;

    assign bit_end    = half_end && second_half;
    assign phase      = phase_q;
    assign bit_idx    = idx_q;
    assign shift_now  = bit_end && (phase_q == PH_DATA);
    assign sample_now = half_end && !second_half && (phase_q == PH_DATA);
    assign finish_now = shift_now && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (accept) begin
            phase_q <= PH_START;
            idx_q   <= '0;
        end else if (bit_end) begin
            unique case (phase_q)
                PH_START: begin
                    phase_q <= PH_DATA;
                    idx_q   <= '0;
                end
                PH_DATA: begin
                    if (idx_q == LAST_IDX) phase_q <= PH_STOP;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                PH_STOP:  phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usync_txpath.sv
module usync_txpath
    import usync_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] load_data,
    input  clkcfg_t           cfg_in,
    input  logic              shift_now,
    input  phase_e            phase,
    input  logic              second_half,
    input  logic              live_pol,
    output logic              txd,
    output logic              sclk
);
    logic [DATA_W-1:0] sh_q;
    clkcfg_t           cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cfg_q <= '0;
        end else if (accept) begin
            sh_q  <= load_data;
            cfg_q <= cfg_in;
        end else if (shift_now) begin
            sh_q <= sh_q >> 1;
        end
    end

    always_comb begin
        unique case (phase)
            PH_START: begin
                txd  = 1'b0;
                sclk = cfg_q.pol;
            end
            PH_DATA: begin
                txd  = sh_q[0];
                sclk = data_clk_level(cfg_q, second_half);
            end
            PH_STOP: begin
                txd  = 1'b1;
                sclk = cfg_q.pol;
            end
            default: begin
                txd  = 1'b1;
                sclk = live_pol;
            end
        endcase
    end
endmodule

// File: rtl/usync_rxpath.sv
module usync_rxpath #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_now,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              rxd,
    input  logic              finish_now,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);
    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            rx_data <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= finish_now;
            if (sample_now) acc_q[bit_idx] <= rxd;
            if (finish_now) rx_data <= acc_q;
        end
    end
endmodule

// File: rtl/usync_master.sv
module usync_master
    import usync_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              sclk,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);
    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    logic             accept;
    logic             half_end;
    logic             second_half;
    logic             shift_now;
    logic             sample_now;
    logic             finish_now;
    clkcfg_t          cfg_now;

    assign tx_ready    = (phase == PH_IDLE);
    assign accept      = tx_valid && tx_ready;
    assign cfg_now.pol = cfg_cpol;
    assign cfg_now.pha = cfg_cpha;

    usync_timer #(.DIV_W(DIV_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .run         (!tx_ready),
        .div_in      (baud_div),
        .half_end    (half_end),
        .second_half (second_half)
    );

    usync_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .half_end    (half_end),
        .second_half (second_half),
        .phase       (phase),
        .bit_idx     (bit_idx),
        .shift_now   (shift_now),
        .sample_now  (sample_now),
        .finish_now  (finish_now)
    );

    usync_txpath #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .load_data   (tx_data),
        .cfg_in      (cfg_now),
        .shift_now   (shift_now),
        .phase       (phase),
        .second_half (second_half),
        .live_pol    (cfg_cpol),
        .txd         (txd),
        .sclk        (sclk)
    );

    usync_rxpath #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .sample_now  (sample_now),
        .bit_idx     (bit_idx),
        .rxd         (rxd),
        .finish_now  (finish_now),
        .rx_data     (rx_data),
        .rx_done     (rx_done)
    );
endmodule

// File: rtl/usync_checker.sv
module usync_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_cpol,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              txd,
    input logic              sclk,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_done
);
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    p_idle_clk_level_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (sclk == cfg_cpol));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_start_follows_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    p_done_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (!tx_ready && txd));

    p_rxdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> $stable(rx_data));
endmodule

bind usync_master usync_checker #(.DATA_W(DATA_W)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .cfg_cpol (cfg_cpol),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .sclk     (sclk),
    .rx_data  (rx_data),
    .rx_done  (rx_done)
);

// File: tb/tb_usync_master.sv
module tb_usync_master;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_cpol, cfg_cpha;
    logic [15:0] baud_div;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready, txd, sclk, rxd, rx_done;
    logic [7:0]  rx_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    usync_master dut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .baud_div(baud_div), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .sclk(sclk), .rxd(rxd),
        .rx_data(rx_data), .rx_done(rx_done)
    );

    typedef struct {
        bit [7:0] txb;
        bit [7:0] rxb;
        bit       pol;
        bit       pha;
        int       div;
        bit       noise;
        bit       flip;
        int       gap;
    } frame_t;

    typedef struct {
        bit       txd;
        bit       sclk;
        bit       rxd;
        bit       done;
        bit [7:0] rxb;
        string    ttag;
        string    ctag;
        bit       flip_here;
    } ent_t;

    frame_t frames[$];
    ent_t   q[$];

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected per-cycle line activity after an acceptance edge
    task automatic build(frame_t f);
        int h;
        h = (f.div == 0) ? 1 : f.div;
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < 2 * h; c++) begin
                ent_t e;
                bit hf;
                hf = (c >= h);
                e.done = (s == 9) && (c == 0);
                e.rxb  = f.rxb;
                e.flip_here = f.flip && (s == 2) && (c == 0);
                e.ttag = (f.div == 0) ? "R9" : "R3";
                if (s == 0) begin
                    e.txd = 1'b0; e.sclk = f.pol; e.rxd = 1'b1;
                    e.ctag = f.flip ? "R8" : "R4";
                end else if (s == 9) begin
                    e.txd = 1'b1; e.sclk = f.pol; e.rxd = 1'b1;
                    e.ctag = f.flip ? "R8" : "R4";
                end else begin
                    e.txd  = f.txb[s-1];
                    e.sclk = f.pol ^ (f.pha ^ hf);
                    // opposite level in the second half exposes a late sample
                    e.rxd  = hf ? ~f.rxb[s-1] : f.rxb[s-1];
                    e.ctag = f.flip ? "R8" : "R5";
                end
                q.push_back(e);
            end
        end
    endtask

    initial begin
        frame_t  f;
        bit [7:0] last_rx;
        int      gap;
        int      k;

        frames.push_back('{8'hA5, 8'h3C, 1'b0, 1'b0, 2, 1'b0, 1'b0, 2});
        frames.push_back('{8'h01, 8'h80, 1'b0, 1'b1, 3, 1'b0, 1'b0, 3});
        frames.push_back('{8'hFE, 8'h7F, 1'b1, 1'b0, 1, 1'b0, 1'b0, 0});
        frames.push_back('{8'h96, 8'hC3, 1'b1, 1'b1, 2, 1'b1, 1'b0, 1});
        frames.push_back('{8'h00, 8'hFF, 1'b0, 1'b0, 0, 1'b0, 1'b0, 2});
        frames.push_back('{8'hFF, 8'h00, 1'b1, 1'b1, 4, 1'b0, 1'b1, 1});
        frames.push_back('{8'h5A, 8'hA5, 1'b1, 1'b0, 3, 1'b1, 1'b0, 5});
        frames.push_back('{8'hC3, 8'h69, 1'b0, 1'b1, 1, 1'b0, 1'b0, 0});
        frames.push_back('{8'h3C, 8'h96, 1'b0, 1'b1, 2, 1'b1, 1'b1, 0});

        rst = 1'b1; cfg_cpol = 1'b1; cfg_cpha = 1'b0; baud_div = 16'd2;
        tx_data = 8'h00; tx_valid = 1'b1; rxd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state, offered byte not taken while in reset
        chk("R10 tx_ready", tx_ready, 1);
        chk("R10 txd", txd, 1);
        chk("R10 rx_done", rx_done, 0);
        chk("R10 rx_data", rx_data, 0);
        chk("R1 sclk idle", sclk, cfg_cpol);
        tx_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R10 tx_ready after reset", tx_ready, 1);
        // R1: idle clock level follows the live polarity input
        cfg_cpol = 1'b0;
        @(negedge clk);
        chk("R1 sclk follows cpol", sclk, 0);
        last_rx = 8'h00;
        gap = 2;
        k = 0;

        while (frames.size() > 0 || q.size() > 0 || gap > 0) begin
            @(negedge clk);
            k++;
            if (q.size() > 0) begin
                ent_t e;
                e = q.pop_front();
                chk(e.ttag, txd, e.txd);
                chk(e.ctag, sclk, e.sclk);
                chk("R2 busy", tx_ready, 0);
                chk("R7 done", rx_done, e.done);
                if (e.done) begin
                    chk("R6 rx byte", rx_data, e.rxb);
                    last_rx = e.rxb;
                end else begin
                    chk("R7 hold", rx_data, last_rx);
                end
                rxd = e.rxd;
                // R2: offers while busy are ignored
                tx_valid = f.noise && k[0];
                tx_data  = 8'(k * 37);
                if (e.flip_here) begin
                    cfg_cpol = ~cfg_cpol;
                    cfg_cpha = ~cfg_cpha;
                    baud_div = 16'd7;
                end
            end else begin
                chk("R1 idle ready", tx_ready, 1);
                chk("R1 idle txd", txd, 1);
                chk("R1 idle sclk", sclk, cfg_cpol);
                chk("R7 no done", rx_done, 0);
                chk("R7 hold idle", rx_data, last_rx);
                rxd = 1'b1;
                if (gap > 0) begin
                    gap--;
                    tx_valid = 1'b0;
                end else if (frames.size() > 0) begin
                    f = frames.pop_front();
                    cfg_cpol = f.pol;
                    cfg_cpha = f.pha;
                    baud_div = 16'(f.div);
                    tx_data  = f.txb;
                    tx_valid = 1'b1;
                    gap      = f.gap;
                    build(f);
                end else begin
                    tx_valid = 1'b0;
                end
            end
        end
        tx_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R1 final idle", tx_ready, 1);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog R2 actual=0 expected=1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule